// File: doc/BRIEF.md
# ROM Emulation Memory Mapper

This block holds the byte memory that stands in for up to four boot ROM devices on a target board. A host downloads an image one byte at a time through a write port, addressing it in the target's system address space. Configuration registers give the window's start address and byte length, the device size, the device data width, the system ROM bus width and the byte order of the image. From these settings the block works out which socket, which device word and which byte lane each image byte belongs to, and stores it there.

On the target side every socket has its own chip enable and device address. Each socket reads back its device data from the shared memory. The read path has no register in it, so read data follows the address in the same cycle.

The memory is sized from one parameter, `BASE_BYTES`, which is the byte count of the smallest (512 Kbit) device. The total memory is 64 times that. At 65536 it is 4 MB. The default of 32 keeps the array small.

Top module: `romemu_mapper`

## Requirements
- R1: After reset the start address, the length and the mode are zero. Both flags are clear and `hostWrReady` is high.
- R2: A configuration write targets one register chosen by `cfgSel`:
  - 0 selects the start address.
  - 1 selects the length.
  - 2 selects the mode, with these fields:
    - bits [2:0] are the size code: 0 is 512 Kbit and each step doubles.
    - bit 3 set means 16-bit devices.
    - bits [5:4] give the bus width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits.
    - bit 6 set means big-endian.
  - Selector 3 changes nothing.
- R3: With 8-bit devices on an 8-bit bus, sockets 0 to 3 hold consecutive device-sized regions of the window, from low to high.
- R4: With 8-bit devices on a wider bus, adjacent sockets form byte lanes, lowest lane first.
  - On a 16-bit bus, sockets 0 and 1 serve the lower region and sockets 2 and 3 the upper one.
  - On a 32-bit bus, all four sockets form one region.
- R5: With 16-bit devices, only sockets 0 and 1 are used. A device word takes its low byte from the lower image offset. Sockets 2 and 3 read 16'hFFFF.
- R6: A device holds `BASE_BYTES` shifted left by the size code, with size codes above 5 treated as 5. For 8-bit devices the code is capped at 4. A socket address wraps modulo the device depth.
- R7: In big-endian mode the byte order is reversed within each bus-width word before mapping.
- R8: A start address that is not a multiple of one bank's span is rejected. A bank's span is the device bytes times the number of lanes. A rejected write sets `startErr` and keeps the old start. An accepted write clears `startErr`.
- R9: The two low bits of a written length are dropped. A length of zero disables emulation: every socket reads 16'hFFFF and every host write falls outside the window.
- R10: An accepted host write outside the window, or one that maps past the last socket, leaves memory unchanged. It sets `oorFlag`, which then stays set until reset.
- R11: `hostWrReady` is low in any cycle where a socket enable is high. A host write only takes effect in a cycle where it is accepted.
- R12: Socket read data depends combinationally on the socket address and enable. A socket whose enable is low reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgWrData | input | HOST_AW | Configuration write value |
| hostWrValid | input | 1 | Download byte is valid |
| hostWrAddr | input | HOST_AW | System address of the download byte |
| hostWrData | input | 8 | Download byte |
| hostWrReady | output | 1 | Download write can be accepted this cycle |
| tgtCe | input | 4 | Per-socket read enable, bit n for socket n |
| tgtAddr | input | 4*(log2(BASE_BYTES)+4) | Per-socket device address, socket n in slice n |
| tgtData | output | 64 | Per-socket device data, socket n in bits 16n+15:16n |
| startErr | output | 1 | Last start address write was rejected |
| oorFlag | output | 1 | Sticky: a download byte fell outside the window |

## Verification
Some properties are checked on every cycle:
- No write commits while a socket enable is high.
- `oorFlag` never clears once set.
- A committed write always lies inside the window.
- A disabled window or 16-bit mode drives the idle sockets to all ones.
- A rejected start write leaves the start register unchanged.
- The length register stays aligned.

Only scenarios can show whether bytes land in the right socket, word and lane. So the bench downloads a known image under several combinations of device width, bus width, size and byte order, and reads it back at chosen addresses. It also covers aliasing, the size cap, the collision stall and the ignored cases.

// File: rtl/romemu_pkg.sv
package romemu_pkg;

  // Mode register layout, MSB first: [6] big-endian, [5:4] bus, [3] wide, [2:0] size
  typedef struct packed {
    logic       bigEndian;
    logic [1:0] busCode;
    logic       romWide;
    logic [2:0] sizeCode;
  } romModeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic commitWrite;
    logic readEnable;
  } ctrlStrobeT;

  // Log2 geometry of the current mode
  typedef struct packed {
    logic [4:0] romLog;
    logic [4:0] lanesLog;
    logic [4:0] wLog;
    logic [4:0] devWordsLog;
    logic [4:0] spanLog;
  } geomT;

  function automatic geomT calcGeom(romModeT m, int unsigned baseLog);
    geomT       g;
    logic [4:0] busLog;
    logic [4:0] sizeEff;
    logic [4:0] devBytesLog;
    busLog   = (m.busCode == 2'd0) ? 5'd0 : (m.busCode == 2'd1) ? 5'd1 : 5'd2;
    g.romLog = {4'd0, m.romWide};
    sizeEff  = (m.sizeCode > 3'd5) ? 5'd5 : {2'd0, m.sizeCode};
    if (!m.romWide && sizeEff > 5'd4) sizeEff = 5'd4;
    g.lanesLog    = (busLog > g.romLog) ? busLog - g.romLog : 5'd0;
    g.wLog        = g.lanesLog + g.romLog;
    devBytesLog   = 5'(baseLog) + sizeEff;
    g.devWordsLog = devBytesLog - g.romLog;
    g.spanLog     = devBytesLog + g.lanesLog;
    return g;
  endfunction

endpackage

// File: rtl/romemu_ctrl.sv
module romemu_ctrl
  import romemu_pkg::*;
#(
  parameter int HOST_AW  = 32,
  parameter int BASE_LOG = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [HOST_AW-1:0] cfgWrData,
  input  logic               hostWrValid,
  input  logic               hostHit,
  input  logic [3:0]         tgtCe,
  output logic               hostWrReady,
  output logic               startErr,
  output logic               oorFlag,
  output logic [HOST_AW-1:0] startAddr,
  output logic [HOST_AW-1:0] lenBytes,
  output romModeT            mode,
  output ctrlStrobeT         strobe
);

  logic [4:0]         spanLog;
  logic [HOST_AW-1:0] alignMask;
  logic               startOk;
  logic               hostAccept;

  always_comb begin
    spanLog     = calcGeom(mode, BASE_LOG).spanLog;
    alignMask   = (HOST_AW'(1) << spanLog) - HOST_AW'(1);
    startOk     = (cfgWrData & alignMask) == '0;
    hostWrReady = ~|tgtCe;
    hostAccept  = hostWrValid & hostWrReady;
    strobe.commitWrite = hostAccept & hostHit;
    strobe.readEnable  = lenBytes != '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      lenBytes  <= '0;
      mode      <= '0;
      startErr  <= 1'b0;
      oorFlag   <= 1'b0;
    end else begin
      if (cfgWe) begin
        case (cfgSel)
          2'd0: begin
            if (startOk) begin
              startAddr <= cfgWrData;
              startErr  <= 1'b0;
            end else begin
              startErr  <= 1'b1;
            end
          end
          2'd1:    lenBytes <= {cfgWrData[HOST_AW-1:2], 2'b00};
          2'd2:    mode     <= romModeT'(cfgWrData[6:0]);
          default: ;
        endcase
      end
      if (hostAccept && !hostHit) oorFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/romemu_datapath.sv
module romemu_datapath
  import romemu_pkg::*;
#(
  parameter int HOST_AW  = 32,
  parameter int BASE_LOG = 5,
  parameter int SOCK_AW  = BASE_LOG + 4,
  parameter int MEM_AW   = BASE_LOG + 6
) (
  input  logic                 clk,
  input  logic [HOST_AW-1:0]   startAddr,
  input  logic [HOST_AW-1:0]   lenBytes,
  input  romModeT              mode,
  input  ctrlStrobeT           strobe,
  input  logic [HOST_AW-1:0]   hostWrAddr,
  input  logic [7:0]           hostWrData,
  input  logic [3:0]           tgtCe,
  input  logic [4*SOCK_AW-1:0] tgtAddr,
  output logic                 hostHit,
  output logic [63:0]          tgtData
);

  localparam int MEM_BYTES = 1 << MEM_AW;

  logic [7:0] memArr [MEM_BYTES];

  geomT               g;
  logic [4:0]         sockLog;
  logic [4:0]         banksLog;
  logic [4:0]         strideLog;
  logic [HOST_AW-1:0] offset, offSw, swapMask, byteInBus, lane, byteInRom;
  logic [HOST_AW-1:0] wordIdx, bank, devWord, socketIdx, memIdx;
  logic               inWindow, bankOk;

  // Host side: system address -> socket, device word, byte
  always_comb begin
    g         = calcGeom(mode, BASE_LOG);
    sockLog   = mode.romWide ? 5'd1 : 5'd2;
    banksLog  = sockLog - g.lanesLog;
    strideLog = 5'(MEM_AW) - sockLog;
    offset    = hostWrAddr - startAddr;
    inWindow  = (hostWrAddr >= startAddr) && (offset < lenBytes);
    swapMask  = (HOST_AW'(1) << g.wLog) - HOST_AW'(1);
    offSw     = mode.bigEndian ? (offset ^ swapMask) : offset;
    byteInBus = offSw & swapMask;
    lane      = byteInBus >> g.romLog;
    byteInRom = offSw & HOST_AW'(mode.romWide);
    wordIdx   = offSw >> g.wLog;
    bank      = offSw >> g.spanLog;
    devWord   = wordIdx & ((HOST_AW'(1) << g.devWordsLog) - HOST_AW'(1));
    bankOk    = bank < (HOST_AW'(1) << banksLog);
    socketIdx = (bank << g.lanesLog) | lane;
    memIdx    = (socketIdx << strideLog) | (devWord << g.romLog) | byteInRom;
    hostHit   = inWindow & bankOk;
  end

  always_ff @(posedge clk) begin
    if (strobe.commitWrite) memArr[memIdx[MEM_AW-1:0]] <= hostWrData;
  end

  // Target side: one read path per socket
  for (genvar s = 0; s < 4; s++) begin : g_sock
    logic [SOCK_AW-1:0] rawAddr, wordSel;
    logic [SOCK_AW:0]   wordSpan;
    logic [MEM_AW-1:0]  narrowIdx;
    logic [15:0]        narrowData, wideData;

    always_comb begin
      rawAddr    = tgtAddr[s*SOCK_AW +: SOCK_AW];
      wordSpan   = (SOCK_AW+1)'(1) << g.devWordsLog;
      wordSel    = rawAddr & SOCK_AW'(wordSpan - 1'b1);
      narrowIdx  = (MEM_AW'(s) << (MEM_AW-2)) | MEM_AW'(wordSel);
      narrowData = {8'h00, memArr[narrowIdx]};
    end

    if (s < 2) begin : g_wide
      logic [MEM_AW-1:0] wideIdx;
      always_comb begin
        wideIdx  = (MEM_AW'(s) << (MEM_AW-1)) | (MEM_AW'(wordSel) << 1);
        wideData = {memArr[wideIdx | MEM_AW'(1)], memArr[wideIdx]};
      end
    end else begin : g_nowide
      assign wideData = 16'hFFFF;
    end

    assign tgtData[s*16 +: 16] = (!strobe.readEnable || !tgtCe[s]) ? 16'hFFFF :
                                 (mode.romWide ? wideData : narrowData);
  end

endmodule

// File: rtl/romemu_mapper.sv
module romemu_mapper
  import romemu_pkg::*;
#(
  parameter int HOST_AW    = 32,
  parameter int BASE_BYTES = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cfgWe,
  input  logic [1:0]                           cfgSel,
  input  logic [HOST_AW-1:0]                   cfgWrData,
  input  logic                                 hostWrValid,
  input  logic [HOST_AW-1:0]                   hostWrAddr,
  input  logic [7:0]                           hostWrData,
  output logic                                 hostWrReady,
  input  logic [3:0]                           tgtCe,
  input  logic [4*($clog2(BASE_BYTES)+4)-1:0]  tgtAddr,
  output logic [63:0]                          tgtData,
  output logic                                 startErr,
  output logic                                 oorFlag
);

  localparam int BASE_LOG = $clog2(BASE_BYTES);
  localparam int SOCK_AW  = BASE_LOG + 4;
  localparam int MEM_AW   = BASE_LOG + 6;

  logic [HOST_AW-1:0] startAddr;
  logic [HOST_AW-1:0] lenBytes;
  romModeT            mode;
  ctrlStrobeT         strobe;
  logic               hostHit;

  romemu_ctrl #(.HOST_AW(HOST_AW), .BASE_LOG(BASE_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .hostWrValid(hostWrValid), .hostHit(hostHit), .tgtCe(tgtCe),
    .hostWrReady(hostWrReady), .startErr(startErr), .oorFlag(oorFlag),
    .startAddr(startAddr), .lenBytes(lenBytes), .mode(mode), .strobe(strobe)
  );

  romemu_datapath #(.HOST_AW(HOST_AW), .BASE_LOG(BASE_LOG), .SOCK_AW(SOCK_AW),
                    .MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .startAddr(startAddr), .lenBytes(lenBytes), .mode(mode), .strobe(strobe),
    .hostWrAddr(hostWrAddr), .hostWrData(hostWrData), .tgtCe(tgtCe), .tgtAddr(tgtAddr),
    .hostHit(hostHit), .tgtData(tgtData)
  );

endmodule

// File: rtl/romemu_mapper_chk.sv
module romemu_mapper_chk
  import romemu_pkg::*;
#(
  parameter int HOST_AW = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [3:0]         tgtCe,
  input logic [63:0]        tgtData,
  input logic               oorFlag,
  input logic               startErr,
  input logic [HOST_AW-1:0] hostWrAddr,
  input logic [HOST_AW-1:0] startAddr,
  input logic [HOST_AW-1:0] lenBytes,
  input romModeT            mode,
  input ctrlStrobeT         strobe
);

  assert_no_write_under_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|tgtCe) |-> !strobe.commitWrite);

  assert_oor_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    oorFlag |=> oorFlag);

  assert_commit_in_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite |-> ((hostWrAddr - startAddr) < lenBytes));

  assert_disabled_reads_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lenBytes == '0) |-> (tgtData == '1));

  assert_len_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    lenBytes[1:0] == 2'b00);

  assert_wide_upper_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    mode.romWide |-> (tgtData[63:32] == 32'hFFFF_FFFF));

  assert_reject_keeps_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startErr) |-> $stable(startAddr));

endmodule

bind romemu_mapper romemu_mapper_chk #(.HOST_AW(HOST_AW)) u_chk (
  .clk(clk), .rstN(rstN), .tgtCe(tgtCe), .tgtData(tgtData), .oorFlag(oorFlag),
  .startErr(startErr), .hostWrAddr(hostWrAddr), .startAddr(startAddr),
  .lenBytes(lenBytes), .mode(mode), .strobe(strobe)
);

// File: tb/romemu_mapper_bench.sv
module romemu_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int SA   = 9;
  localparam logic [31:0] BASE = 32'h1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [AW-1:0] cfgWrData = '0;
  logic          hostWrValid = 1'b0;
  logic [AW-1:0] hostWrAddr = '0;
  logic [7:0]    hostWrData = '0;
  logic          hostWrReady;
  logic [3:0]    tgtCe = '0;
  logic [4*SA-1:0] tgtAddr = '0;
  logic [63:0]   tgtData;
  logic          startErr, oorFlag;

  int checks = 0;
  int errors = 0;

  romemu_mapper #(.HOST_AW(AW), .BASE_BYTES(32)) u_romemu_mapper (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .hostWrValid(hostWrValid), .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .hostWrReady(hostWrReady), .tgtCe(tgtCe), .tgtAddr(tgtAddr), .tgtData(tgtData),
    .startErr(startErr), .oorFlag(oorFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kind: 0 = 8-bit read, 1 = 16-bit read, 2 = all ones
  typedef struct packed {
    logic [6:0]  mode;
    logic [15:0] len;
    logic [1:0]  sock;
    logic [15:0] addr;
    logic [15:0] offLo;
    logic [15:0] offHi;
    logic [1:0]  kind;
  } vecT;

  localparam int NV = 25;
  localparam vecT VECS [NV] = '{
    '{7'h00, 16'd128, 2'd0, 16'd0,   16'd0,   16'd0,  2'd0},
    '{7'h00, 16'd128, 2'd1, 16'd5,   16'd37,  16'd0,  2'd0},
    '{7'h00, 16'd128, 2'd3, 16'd31,  16'd127, 16'd0,  2'd0},
    '{7'h00, 16'd128, 2'd2, 16'd40,  16'd72,  16'd0,  2'd0},
    '{7'h10, 16'd128, 2'd0, 16'd3,   16'd6,   16'd0,  2'd0},
    '{7'h10, 16'd128, 2'd1, 16'd3,   16'd7,   16'd0,  2'd0},
    '{7'h10, 16'd128, 2'd2, 16'd0,   16'd64,  16'd0,  2'd0},
    '{7'h10, 16'd128, 2'd3, 16'd31,  16'd127, 16'd0,  2'd0},
    '{7'h20, 16'd128, 2'd0, 16'd0,   16'd0,   16'd0,  2'd0},
    '{7'h20, 16'd128, 2'd3, 16'd2,   16'd11,  16'd0,  2'd0},
    '{7'h20, 16'd128, 2'd1, 16'd31,  16'd125, 16'd0,  2'd0},
    '{7'h60, 16'd128, 2'd0, 16'd0,   16'd3,   16'd0,  2'd0},
    '{7'h60, 16'd128, 2'd3, 16'd1,   16'd4,   16'd0,  2'd0},
    '{7'h60, 16'd128, 2'd2, 16'd5,   16'd21,  16'd0,  2'd0},
    '{7'h18, 16'd64,  2'd0, 16'd0,   16'd0,   16'd1,  2'd1},
    '{7'h18, 16'd64,  2'd1, 16'd15,  16'd62,  16'd63, 2'd1},
    '{7'h18, 16'd64,  2'd2, 16'd0,   16'd0,   16'd0,  2'd2},
    '{7'h58, 16'd64,  2'd1, 16'd2,   16'd37,  16'd36, 2'd1},
    '{7'h58, 16'd64,  2'd0, 16'd0,   16'd1,   16'd0,  2'd1},
    '{7'h28, 16'd64,  2'd1, 16'd0,   16'd2,   16'd3,  2'd1},
    '{7'h28, 16'd64,  2'd0, 16'd15,  16'd60,  16'd61, 2'd1},
    '{7'h01, 16'd256, 2'd1, 16'd0,   16'd64,  16'd0,  2'd0},
    '{7'h01, 16'd256, 2'd3, 16'd63,  16'd255, 16'd0,  2'd0},
    '{7'h05, 16'd2048,2'd1, 16'd0,   16'd512, 16'd0,  2'd0},
    '{7'h05, 16'd2048,2'd3, 16'd511, 16'd2047,16'd0,  2'd0}
  };

  function automatic logic [7:0] pat(input int o);
    return 8'((o * 7 + 3) % 256);
  endfunction

  function automatic string reqOf(input logic [6:0] m);
    if (m[6])          return "R7";
    if (m[3])          return "R5";
    if (m[2:0] != 0)   return "R6";
    if (m[5:4] != 0)   return "R4";
    return "R3";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk); hostWrValid = 1'b1; hostWrAddr = a; hostWrData = d;
    @(negedge clk); hostWrValid = 1'b0;
  endtask

  task automatic download(input int len);
    for (int o = 0; o < len; o++) hostWrite(BASE + 32'(o), pat(o));
  endtask

  task automatic readSock(input int s, input int a, output logic [15:0] d);
    @(negedge clk);
    tgtCe = '0; tgtCe[s] = 1'b1; tgtAddr[s*SA +: SA] = SA'(a);
    #2 d = tgtData[s*16 +: 16];
    tgtCe = '0;
  endtask

  task automatic setup(input logic [6:0] m, input int len);
    cfgWrite(2'd2, {25'd0, m});
    cfgWrite(2'd0, BASE);
    cfgWrite(2'd1, 32'(len));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] exp;
    doReset();

    // R1 reset state; R9 zero length reads all ones
    @(negedge clk); #2;
    chk("R1 ready", {31'd0, hostWrReady}, 32'd1);
    chk("R1 startErr", {31'd0, startErr}, 32'd0);
    chk("R1 oorFlag", {31'd0, oorFlag}, 32'd0);
    readSock(0, 0, rd);
    chk("R1 disabled read", {16'd0, rd}, 32'h0000_FFFF);

    // Table walk: mapping under several modes
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || VECS[i].mode != VECS[i-1].mode || VECS[i].len != VECS[i-1].len) begin
        setup(VECS[i].mode, int'(VECS[i].len));
        download(int'(VECS[i].len));
      end
      readSock(int'(VECS[i].sock), int'(VECS[i].addr), rd);
      case (VECS[i].kind)
        2'd0:    exp = {8'h00, pat(int'(VECS[i].offLo))};
        2'd1:    exp = {pat(int'(VECS[i].offHi)), pat(int'(VECS[i].offLo))};
        default: exp = 16'hFFFF;
      endcase
      chk(reqOf(VECS[i].mode), {16'd0, rd}, {16'd0, exp});
    end

    // Back to 8-bit devices on an 8-bit bus
    setup(7'h00, 128);
    download(128);

    // R12: data follows address within one low clock phase
    @(negedge clk);
    tgtCe = 4'b0010; tgtAddr[SA +: SA] = SA'(5);
    #1 chk("R12 first addr", {16'd0, tgtData[31:16]}, {24'd0, pat(37)});
    tgtAddr[SA +: SA] = SA'(6);
    #1 chk("R12 second addr", {16'd0, tgtData[31:16]}, {24'd0, pat(38)});
    tgtCe = 4'b0000;
    #1 chk("R12 disabled socket", {16'd0, tgtData[31:16]}, 32'h0000_FFFF);

    // R2: selector 3 has no effect
    cfgWrite(2'd3, 32'hFFFF_FFFF);
    readSock(1, 5, rd);
    chk("R2 unused selector", {16'd0, rd}, {24'd0, pat(37)});

    // R8: misaligned start rejected, aligned start accepted
    cfgWrite(2'd0, BASE + 32'h10);
    chk("R8 reject flag", {31'd0, startErr}, 32'd1);
    hostWrite(BASE, 8'hA5);
    readSock(0, 0, rd);
    chk("R8 old start kept", {16'd0, rd}, 32'h0000_00A5);
    cfgWrite(2'd0, BASE + 32'h20);
    chk("R8 accept clears flag", {31'd0, startErr}, 32'd0);
    hostWrite(BASE + 32'h20, 8'h3C);
    readSock(0, 0, rd);
    chk("R8 new start used", {16'd0, rd}, 32'h0000_003C);
    cfgWrite(2'd0, BASE);

    // R10: write past the last socket ignored, flag sticky
    hostWrite(BASE + 32'd128, 8'h77);
    chk("R10 oor set", {31'd0, oorFlag}, 32'd1);
    readSock(0, 0, rd);
    chk("R10 memory untouched", {16'd0, rd}, 32'h0000_003C);
    hostWrite(BASE + 32'd1, 8'h55);
    chk("R10 oor sticky", {31'd0, oorFlag}, 32'd1);
    hostWrite(BASE - 32'd1, 8'h66);
    readSock(3, 31, rd);
    chk("R10 below window ignored", {16'd0, rd}, {24'd0, pat(127)});

    // R9: length low bits dropped
    doReset();
    setup(7'h00, 126);
    hostWrite(BASE + 32'd125, 8'h11);
    chk("R9 masked length oor", {31'd0, oorFlag}, 32'd1);
    readSock(3, 29, rd);
    chk("R9 masked length no write", {16'd0, rd}, {24'd0, pat(125)});
    cfgWrite(2'd1, 32'd0);
    readSock(1, 5, rd);
    chk("R9 zero length reads ones", {16'd0, rd}, 32'h0000_FFFF);

    // R11: collision stalls the host write
    cfgWrite(2'd1, 32'd128);
    @(negedge clk);
    tgtCe = 4'b0001; tgtAddr[0 +: SA] = SA'(2);
    hostWrValid = 1'b1; hostWrAddr = BASE + 32'd2; hostWrData = 8'hEE;
    #2 chk("R11 ready low", {31'd0, hostWrReady}, 32'd0);
    @(negedge clk); #2;
    chk("R11 no commit while stalled", {16'd0, tgtData[15:0]}, {24'd0, pat(2)});
    tgtCe = 4'b0000;
    #1 chk("R11 ready back", {31'd0, hostWrReady}, 32'd1);
    @(negedge clk); hostWrValid = 1'b0;
    readSock(0, 2, rd);
    chk("R11 write after stall", {16'd0, rd}, 32'h0000_00EE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule